// File: doc/BRIEF.md
# Packet Command Phase Sequencer

This block is the host-side interrupt engine for a packet command that moves data by programmed I/O. The requester loads a descriptor: the direction, the total byte count, the first transfer size and the packet length mode. Each device interrupt then starts a service pass. The block reads the status register. It waits and re-checks while the device shows busy. It then reads the interrupt-reason register and the two byte-count registers, and builds a three-bit phase code from them.

Depending on the phase, it does one of four things. It writes the command packet to the data register, moves one burst of 16-bit words between the data register and a local word buffer, completes the request, or ends the request with an error. A non-conformant completion that still shows a data request is tolerated: the pending data is moved first. A data phase that runs against the request's direction is caught as an error. Completion is a single-cycle pulse. The error flag and error code stay valid until the next request.

Top module: `atapi_phase_seq`

## Requirements
- R1: Task-file addresses are data 0, error 1, interrupt reason 2, byte count low 4, byte count high 5, status 7. The phase code is formed from reason bit 0 (command/data), reason bit 1 (in/out) and status bit 3 (data request), and is decoded as follows:
  - cd=1, io=0, DRQ=1: command out.
  - cd=0, io=0, DRQ=1: data out.
  - cd=0, io=1, DRQ=1: data in.
  - cd=1, io=1, DRQ=1: done with data pending.
  - cd=1, io=1, DRQ=0: done.
  - cd=0, io=0, DRQ=0: abort.
- R2: On a command-out phase with DRQ set, after at least SETTLE_CYC idle cycles, the block writes packet words with index 0 upward to the data register. It writes 6 words when `req_pkt12_i` was 1 at request start, and 8 words otherwise.
- R3: A command-out phase without DRQ (cd=1, io=0, DRQ=0) completes the request with `err_o`=1 and `err_code_o`=0.
- R4: The burst length L is byte count high:low. A burst moves ceil(L/2) words starting at buffer word done_count/2. In data in, each word read from the data register is written to the buffer. In data out, each word read from the buffer is written to the data register. After the burst, the block waits for the next interrupt.
- R5: Direction codes are 01 = device to host, 10 = host to device, 00 = none. A data-out phase on any request that is not host-to-device, or a data-in phase on any request that is not device-to-host, completes with `err_o`=1 and code 0, and moves no data.
- R6: After each burst, the done count grows by L. The transfer size becomes the smaller of its current value and (total − done), where (total − done) is floored at 0.
- R7: A done-with-data-pending phase moves the burst in the request's direction and then completes. With direction none, it completes with `err_o`=1 and code 0, and moves no data.
- R8: On done, abort, or after a done-with-data-pending burst, the block checks the latched status. If ERR (bit 0) or device fault (bit 5) is set, it reads the error register and completes with `err_o`=1 and `err_code_o` equal to that register's low byte. Otherwise it completes with `err_o`=0.
- R9: The remaining phase code (cd=0, io=1, DRQ=0) completes with `err_o`=1 and code 0.
- R10: If status bit 7 (busy) is set when the interrupt is serviced, the block waits at least BSY_CYC cycles and reads status again. It ignores the interrupt unless DRQ is then set; otherwise it continues the service pass with the new status.
- R11: After reset, and after each completion, `busy_o`=0. `done_o` is high for exactly one cycle per request. `err_o` and `err_code_o` hold their completion values until the next request starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Start a request (sampled while idle) |
| req_dir_i | input | 2 | Direction: 01 device-to-host, 10 host-to-device, 00 none |
| req_bytes_i | input | CW | Total byte count of the request |
| req_xfer_i | input | CW | Initial transfer size |
| req_pkt12_i | input | 1 | 1: 12-byte packet, 0: 16-byte packet |
| pkt_idx_o | output | 3 | Index of the packet word being written |
| pkt_word_i | input | DW | Packet word at `pkt_idx_o` |
| dev_irq_i | input | 1 | Device interrupt |
| tf_addr_o | output | 3 | Task-file register address |
| tf_rd_o | output | 1 | Task-file read strobe |
| tf_wr_o | output | 1 | Task-file write strobe |
| tf_wdata_o | output | DW | Task-file write data |
| tf_rdata_i | input | DW | Task-file read data, valid in the strobe cycle |
| buf_addr_o | output | BAW | Local buffer word address |
| buf_rd_o | output | 1 | Buffer read strobe |
| buf_wr_o | output | 1 | Buffer write strobe |
| buf_wdata_o | output | DW | Buffer write data |
| buf_rdata_i | input | DW | Buffer read data, valid in the strobe cycle |
| busy_o | output | 1 | A request is active |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Completion ended in error |
| err_code_o | output | 8 | Error register value, or 0 for a block-detected error |
| done_cnt_o | output | CW | Bytes moved so far |
| xfer_size_o | output | CW | Current transfer size |

## Verification
The hardest situation to reach is the busy path. The interrupt must be dropped when busy is still up after the wait. It must also be accepted when busy and DRQ are both up. The bench holds status at busy-only for one interrupt and checks that no task-file write, buffer write or completion appears while the block stays busy. It then raises busy together with DRQ and expects the packet. The non-conformant done-with-data-pending phase and both direction mismatches are forced by programming the bench's register model before each interrupt. The scoreboard flags any data moved in those cases as an unexpected item.

// File: rtl/atapi_seq_pkg.sv
package atapi_seq_pkg;
  localparam logic [2:0] TF_DATA   = 3'd0;
  localparam logic [2:0] TF_ERR    = 3'd1;
  localparam logic [2:0] TF_REASON = 3'd2;
  localparam logic [2:0] TF_BCL    = 3'd4;
  localparam logic [2:0] TF_BCH    = 3'd5;
  localparam logic [2:0] TF_STAT   = 3'd7;

  localparam int ST_ERR = 0;
  localparam int ST_DRQ = 3;
  localparam int ST_DF  = 5;
  localparam int ST_BSY = 7;

  localparam logic [1:0] DIR_NONE = 2'b00;
  localparam logic [1:0] DIR_IN   = 2'b01;
  localparam logic [1:0] DIR_OUT  = 2'b10;

  typedef enum logic [2:0] {
    PH_CMD, PH_CMD_NODRQ, PH_DOUT, PH_DIN, PH_DONE_DRQ, PH_DONE, PH_BAD
  } phase_e;

  typedef enum logic [3:0] {
    S_IDLE, S_WAIT, S_STAT, S_BSYW, S_STAT2, S_REASON, S_BCL, S_BCH,
    S_DECODE, S_SETTLE, S_PKT, S_XFER, S_CHKERR, S_ERRRD, S_FIN
  } state_e;
endpackage

// File: rtl/atapi_phase_dec.sv
module atapi_phase_dec
  import atapi_seq_pkg::*;
(
  input  logic   drq_i,
  input  logic   io_i,
  input  logic   cd_i,
  output phase_e phase_o
);
  always_comb begin
    unique case ({drq_i, io_i, cd_i})
      3'b101:         phase_o = PH_CMD;
      3'b001:         phase_o = PH_CMD_NODRQ;
      3'b100:         phase_o = PH_DOUT;
      3'b110:         phase_o = PH_DIN;
      3'b111:         phase_o = PH_DONE_DRQ;
      3'b011, 3'b000: phase_o = PH_DONE;
      default:        phase_o = PH_BAD;
    endcase
  end
endmodule

// File: rtl/atapi_wait_timer.sv
module atapi_wait_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] val_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (start_i)           cnt_q <= val_i;
    else if (cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/atapi_xfer_track.sv
module atapi_xfer_track #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] bytes_i,
  input  logic [CW-1:0] xfer_i,
  input  logic          step_i,
  input  logic [CW-1:0] len_i,
  output logic [CW-1:0] done_o,
  output logic [CW-1:0] xfer_o
);
  logic [CW-1:0] bytes_q, done_q, xfer_q, nxt_done, remain;

  assign nxt_done = done_q + len_i;
  assign remain   = (bytes_q > nxt_done) ? bytes_q - nxt_done : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bytes_q <= '0;
      done_q  <= '0;
      xfer_q  <= '0;
    end else if (load_i) begin
      bytes_q <= bytes_i;
      done_q  <= '0;
      xfer_q  <= xfer_i;
    end else if (step_i) begin
      done_q  <= nxt_done;
      xfer_q  <= (remain < xfer_q) ? remain : xfer_q;
    end
  end

  assign done_o = done_q;
  assign xfer_o = xfer_q;

  p_xfer_shrinks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> xfer_o <= $past(xfer_o));
  p_done_adv_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> done_o == $past(done_o) + $past(len_i));
endmodule

// File: rtl/atapi_phase_seq.sv
module atapi_phase_seq
  import atapi_seq_pkg::*;
#(
  parameter int DW         = 16,
  parameter int CW         = 16,
  parameter int BAW        = 10,
  parameter int SETTLE_CYC = 10,
  parameter int BSY_CYC    = 100
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_valid_i,
  input  logic [1:0]     req_dir_i,
  input  logic [CW-1:0]  req_bytes_i,
  input  logic [CW-1:0]  req_xfer_i,
  input  logic           req_pkt12_i,
  output logic [2:0]     pkt_idx_o,
  input  logic [DW-1:0]  pkt_word_i,
  input  logic           dev_irq_i,
  output logic [2:0]     tf_addr_o,
  output logic           tf_rd_o,
  output logic           tf_wr_o,
  output logic [DW-1:0]  tf_wdata_o,
  input  logic [DW-1:0]  tf_rdata_i,
  output logic [BAW-1:0] buf_addr_o,
  output logic           buf_rd_o,
  output logic           buf_wr_o,
  output logic [DW-1:0]  buf_wdata_o,
  input  logic [DW-1:0]  buf_rdata_i,
  output logic           busy_o,
  output logic           done_o,
  output logic           err_o,
  output logic [7:0]     err_code_o,
  output logic [CW-1:0]  done_cnt_o,
  output logic [CW-1:0]  xfer_size_o
);
  localparam int BPW       = DW / 8;
  localparam int SH        = $clog2(BPW);
  localparam int PKT_SHORT = 12 / BPW;
  localparam int PKT_LONG  = 16 / BPW;
  localparam int TMAX      = (SETTLE_CYC > BSY_CYC) ? SETTLE_CYC : BSY_CYC;
  localparam int TW        = $clog2(TMAX + 1);

  state_e        state_q, state_d;
  logic [1:0]    dir_q;
  logic          pkt12_q, drq_q, fault_q, io_q, cd_q, fin_after_q;
  logic [15:0]   len_q;
  logic [CW-1:0] wcnt_q, words, base;
  logic [CW:0]   words_x;
  logic [2:0]    pidx_q, pkt_last;
  logic          err_q;
  logic [7:0]    code_q;
  logic          tmr_start, tmr_exp, trk_step, fail;
  logic [TW-1:0] tmr_val;
  phase_e        phase;

  atapi_phase_dec u_dec (
    .drq_i(drq_q), .io_i(io_q), .cd_i(cd_q), .phase_o(phase)
  );

  atapi_wait_timer #(.W(TW)) u_tmr (
    .clk_i, .rst_ni, .start_i(tmr_start), .val_i(tmr_val), .expired_o(tmr_exp)
  );

  atapi_xfer_track #(.CW(CW)) u_trk (
    .clk_i, .rst_ni,
    .load_i (state_q == S_IDLE && req_valid_i),
    .bytes_i(req_bytes_i), .xfer_i(req_xfer_i),
    .step_i (trk_step), .len_i(CW'(len_q)),
    .done_o (done_cnt_o), .xfer_o(xfer_size_o)
  );

  assign words_x  = ({1'b0, CW'(len_q)} + (CW+1)'(BPW - 1)) >> SH;
  assign words    = words_x[CW-1:0];
  assign base     = done_cnt_o >> SH;
  assign pkt_last = pkt12_q ? 3'(PKT_SHORT - 1) : 3'(PKT_LONG - 1);

  always_comb begin
    state_d   = state_q;
    tmr_start = 1'b0;
    tmr_val   = TW'(SETTLE_CYC);
    trk_step  = 1'b0;
    fail      = 1'b0;
    unique case (state_q)
      S_IDLE:   if (req_valid_i) state_d = S_WAIT;
      S_WAIT:   if (dev_irq_i) state_d = S_STAT;
      S_STAT: begin
        if (tf_rdata_i[ST_BSY]) begin
          tmr_start = 1'b1;
          tmr_val   = TW'(BSY_CYC);
          state_d   = S_BSYW;
        end else state_d = S_REASON;
      end
      S_BSYW:   if (tmr_exp) state_d = S_STAT2;
      S_STAT2:  state_d = tf_rdata_i[ST_DRQ] ? S_REASON : S_WAIT;
      S_REASON: state_d = S_BCL;
      S_BCL:    state_d = S_BCH;
      S_BCH:    state_d = S_DECODE;
      S_DECODE: begin
        unique case (phase)
          PH_CMD: begin
            tmr_start = 1'b1;
            state_d   = S_SETTLE;
          end
          PH_DONE: state_d = S_CHKERR;
          PH_DOUT, PH_DIN, PH_DONE_DRQ: begin
            if ((phase == PH_DOUT && dir_q != DIR_OUT) ||
                (phase == PH_DIN  && dir_q != DIR_IN)  ||
                (phase == PH_DONE_DRQ && dir_q != DIR_IN && dir_q != DIR_OUT))
              fail = 1'b1;
            else if (words == '0) begin
              trk_step = 1'b1;
              state_d  = (phase == PH_DONE_DRQ) ? S_CHKERR : S_WAIT;
            end else state_d = S_XFER;
          end
          default: fail = 1'b1;
        endcase
        if (fail) state_d = S_FIN;
      end
      S_SETTLE: if (tmr_exp) state_d = S_PKT;
      S_PKT:    if (pidx_q == pkt_last) state_d = S_WAIT;
      S_XFER: begin
        if (wcnt_q == words - 1'b1) begin
          trk_step = 1'b1;
          state_d  = fin_after_q ? S_CHKERR : S_WAIT;
        end
      end
      S_CHKERR: state_d = fault_q ? S_ERRRD : S_FIN;
      S_ERRRD:  state_d = S_FIN;
      S_FIN:    state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      dir_q       <= DIR_NONE;
      pkt12_q     <= 1'b0;
      drq_q       <= 1'b0;
      fault_q     <= 1'b0;
      io_q        <= 1'b0;
      cd_q        <= 1'b0;
      fin_after_q <= 1'b0;
      len_q       <= '0;
      wcnt_q      <= '0;
      pidx_q      <= '0;
      err_q       <= 1'b0;
      code_q      <= '0;
    end else begin
      state_q <= state_d;
      unique case (state_q)
        S_IDLE: if (req_valid_i) begin
          dir_q   <= req_dir_i;
          pkt12_q <= req_pkt12_i;
          err_q   <= 1'b0;
          code_q  <= '0;
        end
        S_STAT, S_STAT2: begin
          drq_q   <= tf_rdata_i[ST_DRQ];
          fault_q <= tf_rdata_i[ST_ERR] | tf_rdata_i[ST_DF];
        end
        S_REASON: begin
          cd_q <= tf_rdata_i[0];
          io_q <= tf_rdata_i[1];
        end
        S_BCL: len_q[7:0]  <= tf_rdata_i[7:0];
        S_BCH: len_q[15:8] <= tf_rdata_i[7:0];
        S_DECODE: begin
          wcnt_q      <= '0;
          pidx_q      <= '0;
          fin_after_q <= (phase == PH_DONE_DRQ);
          if (fail) begin
            err_q  <= 1'b1;
            code_q <= '0;
          end
        end
        S_PKT:  pidx_q <= pidx_q + 1'b1;
        S_XFER: wcnt_q <= wcnt_q + 1'b1;
        S_ERRRD: begin
          err_q  <= 1'b1;
          code_q <= tf_rdata_i[7:0];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    tf_addr_o  = TF_STAT;
    tf_rd_o    = 1'b0;
    tf_wr_o    = 1'b0;
    tf_wdata_o = '0;
    buf_rd_o   = 1'b0;
    buf_wr_o   = 1'b0;
    unique case (state_q)
      S_STAT, S_STAT2: tf_rd_o = 1'b1;
      S_REASON: begin tf_rd_o = 1'b1; tf_addr_o = TF_REASON; end
      S_BCL:    begin tf_rd_o = 1'b1; tf_addr_o = TF_BCL;    end
      S_BCH:    begin tf_rd_o = 1'b1; tf_addr_o = TF_BCH;    end
      S_ERRRD:  begin tf_rd_o = 1'b1; tf_addr_o = TF_ERR;    end
      S_PKT: begin
        tf_wr_o    = 1'b1;
        tf_addr_o  = TF_DATA;
        tf_wdata_o = pkt_word_i;
      end
      S_XFER: begin
        tf_addr_o = TF_DATA;
        if (dir_q == DIR_OUT) begin
          buf_rd_o   = 1'b1;
          tf_wr_o    = 1'b1;
          tf_wdata_o = buf_rdata_i;
        end else begin
          tf_rd_o  = 1'b1;
          buf_wr_o = 1'b1;
        end
      end
      default: ;
    endcase
  end

  assign buf_wdata_o = tf_rdata_i;
  assign buf_addr_o  = BAW'(base + wcnt_q);
  assign pkt_idx_o   = pidx_q;
  assign busy_o      = (state_q != S_IDLE);
  assign done_o      = (state_q == S_FIN);
  assign err_o       = err_q;
  assign err_code_o  = code_q;

  p_rw_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tf_rd_o && tf_wr_o));
  p_bufwr_dir_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_wr_o |-> dir_q == DIR_IN);
  p_bufrd_dir_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_rd_o |-> dir_q == DIR_OUT);
  p_mismatch_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_DECODE && phase == PH_DIN && dir_q != DIR_IN) |=> done_o && err_o);
  p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);
  p_idle_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !tf_rd_o && !tf_wr_o && !buf_wr_o);
endmodule

// File: tb/sim_atapi_phase_seq.sv
module sim_atapi_phase_seq;
  localparam int CLK_PERIOD = 10;
  localparam int WAITC      = 220;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        req_valid = 1'b0, req_pkt12 = 1'b0, dev_irq = 1'b0;
  logic [1:0]  req_dir = 2'b00;
  logic [15:0] req_bytes = '0, req_xfer = '0;
  logic [2:0]  pkt_idx, tf_addr;
  logic [15:0] pkt_word, tf_wdata, tf_rdata, buf_wdata, buf_rdata;
  logic        tf_rd, tf_wr, buf_rd, buf_wr, busy, done, err;
  logic [9:0]  buf_addr;
  logic [7:0]  err_code;
  logic [15:0] done_cnt, xfer_size;

  logic [7:0]  d_stat = '0, d_reason = '0, d_bcl = '0, d_bch = '0, d_err = '0;
  logic [15:0] rd_seq = '0;
  int          exp_seq = 0;
  int          checks = 0, fails = 0;
  bit          finished = 0;

  typedef struct packed { logic [1:0] kind; logic [15:0] a; logic [15:0] d; } item_t;
  item_t exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  atapi_phase_seq u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_dir_i(req_dir),
    .req_bytes_i(req_bytes), .req_xfer_i(req_xfer), .req_pkt12_i(req_pkt12),
    .pkt_idx_o(pkt_idx), .pkt_word_i(pkt_word), .dev_irq_i(dev_irq),
    .tf_addr_o(tf_addr), .tf_rd_o(tf_rd), .tf_wr_o(tf_wr), .tf_wdata_o(tf_wdata),
    .tf_rdata_i(tf_rdata), .buf_addr_o(buf_addr), .buf_rd_o(buf_rd), .buf_wr_o(buf_wr),
    .buf_wdata_o(buf_wdata), .buf_rdata_i(buf_rdata), .busy_o(busy), .done_o(done),
    .err_o(err), .err_code_o(err_code), .done_cnt_o(done_cnt), .xfer_size_o(xfer_size)
  );

  assign pkt_word  = 16'hC000 | 16'(pkt_idx);
  assign buf_rdata = 16'h5000 | 16'(buf_addr);

  always_comb begin
    case (tf_addr)
      3'd0:    tf_rdata = 16'hA000 + rd_seq;
      3'd1:    tf_rdata = {8'h00, d_err};
      3'd2:    tf_rdata = {8'h00, d_reason};
      3'd4:    tf_rdata = {8'h00, d_bcl};
      3'd5:    tf_rdata = {8'h00, d_bch};
      3'd7:    tf_rdata = {8'h00, d_stat};
      default: tf_rdata = 16'h0000;
    endcase
  end

  always_ff @(posedge clk) if (tf_rd && tf_addr == 3'd0) rd_seq <= rd_seq + 1'b1;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(logic [1:0] kind, logic [15:0] a, logic [15:0] d, string tag);
    exp_q.push_back('{kind, a, d});
    tag_q.push_back(tag);
  endtask

  task automatic push_rd(logic [15:0] a, string tag);
    push(2'd1, a, 16'hA000 + 16'(exp_seq), tag);
    exp_seq++;
  endtask

  task automatic push_pkt(int n, string tag);
    for (int i = 0; i < n; i++) push(2'd0, 16'h0, 16'hC000 | 16'(i), tag);
  endtask

  task automatic push_done(logic e, logic [7:0] c, string tag);
    push(2'd2, {15'h0, e}, {8'h0, c}, tag);
  endtask

  // monitor
  always @(negedge clk) begin
    item_t got;
    bit    seen;
    seen = 0;
    if (rst_ni && tf_wr && tf_addr == 3'd0) begin got = '{2'd0, 16'h0, tf_wdata}; seen = 1; end
    if (rst_ni && buf_wr) begin got = '{2'd1, 16'(buf_addr), buf_wdata}; seen = 1; end
    if (rst_ni && done) begin got = '{2'd2, {15'h0, err}, {8'h0, err_code}}; seen = 1; end
    if (seen) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL unexpected item actual=%h expected=none", got);
      end else begin
        item_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (got !== e) begin
          fails++;
          $display("FAIL %s actual=%h expected=%h", t, got, e);
        end
      end
    end
  end

  task automatic start_req(logic [1:0] dir, logic [15:0] bytes, logic [15:0] xfer, logic p12);
    @(posedge clk); #1;
    req_valid = 1; req_dir = dir; req_bytes = bytes; req_xfer = xfer; req_pkt12 = p12;
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic irq(logic [7:0] st, logic [7:0] rs, logic [15:0] len, logic [7:0] e);
    @(posedge clk); #1;
    d_stat = st; d_reason = rs; d_bcl = len[7:0]; d_bch = len[15:8]; d_err = e;
    dev_irq = 1;
    @(posedge clk); #1;
    dev_irq = 0;
    repeat (WAITC) @(posedge clk);
    #1;
  endtask

  task automatic drained(string tag);
    chk({tag, " queue drained"}, exp_q.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1;
    @(negedge clk);
    chk("R11 reset busy", busy, 0);
    chk("R11 reset done", done, 0);
    chk("R11 reset err", err, 0);

    // A: device-to-host, 12-byte packet, two bursts, clean done
    start_req(2'b01, 16'd10, 16'd8, 1'b1);
    push_pkt(6, "R1/R2 12-byte packet");
    irq(8'h08, 8'h01, 16'd0, 8'h00);
    for (int k = 0; k < 4; k++) push_rd(16'(k), "R4 data in burst");
    irq(8'h08, 8'h02, 16'd8, 8'h00);
    chk("R6 done after burst1", done_cnt, 16'd8);
    chk("R6 xfer after burst1", xfer_size, 16'd2);
    push_rd(16'd4, "R4 data in second burst");
    irq(8'h08, 8'h02, 16'd2, 8'h00);
    chk("R6 done after burst2", done_cnt, 16'd10);
    chk("R6 xfer floor", xfer_size, 16'd0);
    push_done(1'b0, 8'h00, "R8 clean done");
    irq(8'h00, 8'h03, 16'd0, 8'h00);
    chk("R11 idle after done", busy, 0);
    drained("A");

    // B: host-to-device, 16-byte packet, odd burst, done with ERR
    start_req(2'b10, 16'd6, 16'd16, 1'b0);
    push_pkt(8, "R2 16-byte packet");
    irq(8'h08, 8'h01, 16'd0, 8'h00);
    for (int k = 0; k < 3; k++) push(2'd0, 16'h0, 16'h5000 | 16'(k), "R4 data out burst");
    irq(8'h08, 8'h00, 16'd5, 8'h00);
    chk("R6 done odd", done_cnt, 16'd5);
    chk("R6 xfer odd", xfer_size, 16'd1);
    push_done(1'b1, 8'h24, "R8 done with ERR");
    irq(8'h41, 8'h03, 16'd0, 8'h24);
    chk("R11 err held", err, 1);
    chk("R11 code held", err_code, 8'h24);
    drained("B");

    // C: data out on a read request
    start_req(2'b01, 16'd8, 16'd8, 1'b1);
    chk("R11 err cleared on start", err, 0);
    push_done(1'b1, 8'h00, "R5 data out on read");
    irq(8'h08, 8'h00, 16'd4, 8'h00);
    chk("R5 nothing moved", done_cnt, 16'd0);
    drained("C");

    // D: data in on a write request
    start_req(2'b10, 16'd8, 16'd8, 1'b1);
    push_done(1'b1, 8'h00, "R5 data in on write");
    irq(8'h08, 8'h02, 16'd4, 8'h00);
    drained("D");

    // E: command out without DRQ
    start_req(2'b01, 16'd8, 16'd8, 1'b1);
    push_done(1'b1, 8'h00, "R3 command without DRQ");
    irq(8'h00, 8'h01, 16'd0, 8'h00);
    drained("E");

    // F: done with data pending, read direction
    start_req(2'b01, 16'd4, 16'd8, 1'b1);
    push_rd(16'd0, "R7 pending data word0");
    push_rd(16'd1, "R7 pending data word1");
    push_done(1'b0, 8'h00, "R7 done after pending data");
    irq(8'h08, 8'h03, 16'd4, 8'h00);
    chk("R7 done count", done_cnt, 16'd4);
    drained("F");

    // G: done with data pending, no direction
    start_req(2'b00, 16'd4, 16'd8, 1'b1);
    push_done(1'b1, 8'h00, "R7 pending data without direction");
    irq(8'h08, 8'h03, 16'd4, 8'h00);
    drained("G");

    // H: unknown phase
    start_req(2'b01, 16'd4, 16'd8, 1'b1);
    push_done(1'b1, 8'h00, "R9 unknown phase");
    irq(8'h00, 8'h02, 16'd0, 8'h00);
    drained("H");

    // I: busy handling, then abort with device fault
    start_req(2'b10, 16'd8, 16'd8, 1'b0);
    irq(8'h80, 8'h01, 16'd0, 8'h00);
    chk("R10 busy-only interrupt ignored", busy, 1);
    drained("R10 ignored");
    push_pkt(8, "R10 busy with DRQ accepted");
    irq(8'h88, 8'h01, 16'd0, 8'h00);
    push_done(1'b1, 8'h04, "R8 abort with fault");
    irq(8'h20, 8'h00, 16'd0, 8'h04);
    drained("I");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule